// File: doc/BRIEF.md
# Fully Associative Write-Back Line Cache

This block is a small data cache between a processor's word port and a slower RAM that only moves whole four-word lines. It holds 16 lines of four 16-bit words, so 64 words in all. Any line of the 16-bit word address space may sit in any slot. A slot is chosen by first using any empty slot. When no slot is empty, the least recently used line is replaced. Stores only change the cached copy. A modified line reaches RAM only when it is replaced or when a flush is requested.

Four requesters share one lookup path. The DMA word port comes first, then flush, then prefetch, then the processor. DMA traffic passes through the cache, so a DMA word write updates the cached copy and a DMA read returns it. A prefetch command is acknowledged in the cycle it is taken and then loads its line in the background. While a line fill, a write-back or a flush is running, the processor and DMA are held off.

Requests are level-held: a requester keeps `*_req` high until it sees the matching acknowledge. On a hit the acknowledge and the read data appear in the same cycle, and the access commits at the next clock edge. On a miss the line is fetched and the held request is then served as a hit. Address bits above bit 15 on the request ports are discarded before use.

Top module: `wb_line_cache`

## Requirements
- R1: Sixteen distinct lines can be resident together. After they are loaded, reading every word of them again causes no RAM read.
- R2: An empty slot is always filled before any resident line is replaced. When all slots are full, a miss replaces the line whose last hit or fill is oldest. Hits and fills both make a line the most recent.
- R3: A store that hits only changes the cache and causes no RAM write. A line that has been modified is written to RAM, whole, when it is replaced. Replacing an unmodified line causes no RAM write.
- R4: Each RAM access moves one whole line. `ram_line_addr` is the word address divided by 4, and word k of the line is carried in bits [16k+15:16k] of `ram_wline` and `ram_rline`. Once `ram_req` is raised, it stays high with a stable address and direction until `ram_ack`.
- R5: A prefetch is acknowledged (`pf_ack`) in the same cycle it is selected, before its RAM read completes. A prefetch of an absent line loads that line. A prefetch of a resident line causes no RAM access and leaves the replacement order unchanged.
- R6: While a fill, write-back or flush is in progress, `cpu_ack` stays low. A processor access that misses is acknowledged only after its line has arrived from RAM.
- R7: A DMA word write updates the cache, filling the line on a miss, and does not write RAM directly. Later processor reads see the written value. A DMA read returns the cached value, including words written by the processor.
- R8: Only the low 16 bits of `cpu_addr`, `dma_addr` and `pf_addr` are used. Requests that differ only in higher bits address the same word.
- R9: A flush writes every modified line back to RAM and then pulses `flush_done`. A second flush with no stores in between causes no RAM write.
- R10: When several requests are pending, DMA is served first, then flush, then prefetch, then the processor. Only one acknowledge is given per cycle.
- R11: After reset all slots are empty and no acknowledge or RAM request is active, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_IN_W | Processor word address; bits above 15 ignored |
| cpu_wdata | input | 16 | Store data |
| cpu_ack | output | 1 | Access served in this cycle |
| cpu_rdata | output | 16 | Load data, valid with cpu_ack |
| pf_req | input | 1 | Prefetch command, held until acknowledged |
| pf_addr | input | ADDR_IN_W | Prefetch word address |
| pf_ack | output | 1 | Prefetch accepted in this cycle |
| dma_req | input | 1 | DMA word transfer request, held until acknowledged |
| dma_we | input | 1 | 1 = DMA writes memory, 0 = DMA reads |
| dma_addr | input | ADDR_IN_W | DMA word address |
| dma_wdata | input | 16 | DMA write data |
| dma_ack | output | 1 | DMA transfer served in this cycle |
| dma_rdata | output | 16 | DMA read data, valid with dma_ack |
| flush_req | input | 1 | Write back all modified lines, held until done |
| flush_done | output | 1 | Flush complete in this cycle |
| ram_req | output | 1 | Line transfer request to RAM |
| ram_we | output | 1 | 1 = line write-back, 0 = line read |
| ram_line_addr | output | 14 | Line number (word address / 4) |
| ram_wline | output | 64 | Line data to RAM, word k in bits [16k+15:16k] |
| ram_ack | input | 1 | One-cycle pulse: transfer finished |
| ram_rline | input | 64 | Line data from RAM, valid with ram_ack |

## Verification
A wrong tag, valid or modified bit does not show up at once. It appears at the next access to that line, or at the next replacement, as a missing or extra RAM transfer, and RAM transfers are what the ports count. A corrupted replacement order shows on the next miss with all slots full: the wrong line is lost, and a later access to the line that should have stayed then makes an unexpected RAM read. A lost modified bit shows as stale RAM data after the next flush, and a spurious one as an extra write during that flush. The tests therefore follow each setup step with the access that exposes its state and compare RAM transfer counts and data.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 16;
    localparam int LINE_WORDS = 4;
    localparam int NUM_LINES  = 16;
    localparam int OFS_W      = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - OFS_W;
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EVICT = 2'd1,
        PH_FILL  = 2'd2,
        PH_FLUSH = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        idx_t   slot;
        tag_t   miss_tag;
        logic   wb_for_flush;
    } ctl_t;

    typedef struct packed {
        logic [NUM_LINES-1:0][TAG_W-1:0]  tags;
        logic [NUM_LINES-1:0][LINE_W-1:0] lines;
        logic [NUM_LINES-1:0]             valid;
        logic [NUM_LINES-1:0]             dirty;
    } store_t;
endpackage

// File: rtl/cache_arbiter.sv
module cache_arbiter
    import cache_pkg::*;
#(
    parameter int ADDR_IN_W = 20
) (
    input  logic                 dma_req,
    input  logic                 dma_we,
    input  logic [ADDR_IN_W-1:0] dma_addr,
    input  word_t                dma_wdata,
    input  logic                 flush_req,
    input  logic                 pf_req,
    input  logic [ADDR_IN_W-1:0] pf_addr,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_IN_W-1:0] cpu_addr,
    input  word_t                cpu_wdata,
    output logic                 sel_dma,
    output logic                 sel_flush,
    output logic                 sel_pf,
    output logic                 sel_cpu,
    output logic [ADDR_W-1:0]    req_addr,
    output logic                 req_we,
    output word_t                req_wdata
);
    always_comb begin
        sel_dma   = dma_req;
        sel_flush = !dma_req && flush_req;
        sel_pf    = !dma_req && !flush_req && pf_req;
        sel_cpu   = !dma_req && !flush_req && !pf_req && cpu_req;
        req_addr  = cpu_addr[ADDR_W-1:0];
        req_we    = cpu_we && sel_cpu;
        req_wdata = cpu_wdata;
        if (sel_dma) begin
            req_addr  = dma_addr[ADDR_W-1:0];
            req_we    = dma_we;
            req_wdata = dma_wdata;
        end else if (sel_pf) begin
            req_addr  = pf_addr[ADDR_W-1:0];
            req_we    = 1'b0;
        end
    end
endmodule

// File: rtl/cache_lookup.sv
module cache_lookup
    import cache_pkg::*;
(
    input  logic [NUM_LINES-1:0][TAG_W-1:0] tags,
    input  logic [NUM_LINES-1:0]            valid,
    input  tag_t                            look_tag,
    output logic [NUM_LINES-1:0]            match,
    output logic                            hit,
    output idx_t                            hit_idx,
    output logic                            free_any,
    output idx_t                            free_idx
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == look_tag);
    end

    always_comb begin
        hit      = |match;
        free_any = ~&valid;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cache_lru.sv
module cache_lru
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic touch_en,
    input  idx_t touch_idx,
    output idx_t victim
);
    typedef struct packed {
        logic [NUM_LINES-1:0][IDX_W-1:0] age;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [NUM_LINES-1:0] oldest;

    always_comb begin
        lru_d  = lru_q;
        victim = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            oldest[i] = (lru_q.age[i] == IDX_W'(NUM_LINES - 1));
            if (oldest[i]) victim = IDX_W'(i);
        end
        if (touch_en) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    lru_d.age[i] = '0;
                end else if (lru_q.age[i] < lru_q.age[touch_idx]) begin
                    lru_d.age[i] = lru_q.age[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) lru_q.age[i] <= IDX_W'(i);
        end else begin
            lru_q <= lru_d;
        end
    end

    AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1); // R2
    AST_LRU_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> victim != $past(touch_idx)); // R2
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache
    import cache_pkg::*;
#(
    parameter int ADDR_IN_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_IN_W-1:0] cpu_addr,
    input  logic [15:0]          cpu_wdata,
    output logic                 cpu_ack,
    output logic [15:0]          cpu_rdata,
    input  logic                 pf_req,
    input  logic [ADDR_IN_W-1:0] pf_addr,
    output logic                 pf_ack,
    input  logic                 dma_req,
    input  logic                 dma_we,
    input  logic [ADDR_IN_W-1:0] dma_addr,
    input  logic [15:0]          dma_wdata,
    output logic                 dma_ack,
    output logic [15:0]          dma_rdata,
    input  logic                 flush_req,
    output logic                 flush_done,
    output logic                 ram_req,
    output logic                 ram_we,
    output logic [13:0]          ram_line_addr,
    output logic [63:0]          ram_wline,
    input  logic                 ram_ack,
    input  logic [63:0]          ram_rline
);
    ctl_t   ctl_d, ctl_q;
    store_t st_d, st_q;

    logic               sel_dma, sel_flush, sel_pf, sel_cpu;
    logic [ADDR_W-1:0]  req_addr;
    logic               req_we;
    word_t              req_wdata;
    tag_t               look_tag;
    ofs_t               ofs;
    logic [NUM_LINES-1:0] match;
    logic               hit, free_any;
    idx_t               hit_idx, free_idx, lru_victim, victim;
    logic               touch_en;
    idx_t               touch_idx;
    logic               start_miss;
    word_t              hit_word;

    assign look_tag = req_addr[ADDR_W-1:OFS_W];
    assign ofs      = req_addr[OFS_W-1:0];
    assign victim   = free_any ? free_idx : lru_victim;
    assign hit_word = st_q.lines[hit_idx][int'(ofs)*WORD_W +: WORD_W];
    assign cpu_rdata = hit_word;
    assign dma_rdata = hit_word;

    cache_arbiter #(.ADDR_IN_W(ADDR_IN_W)) i_arb (
        .dma_req   (dma_req),
        .dma_we    (dma_we),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .flush_req (flush_req),
        .pf_req    (pf_req),
        .pf_addr   (pf_addr),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .sel_dma   (sel_dma),
        .sel_flush (sel_flush),
        .sel_pf    (sel_pf),
        .sel_cpu   (sel_cpu),
        .req_addr  (req_addr),
        .req_we    (req_we),
        .req_wdata (req_wdata)
    );

    cache_lookup i_look (
        .tags     (st_q.tags),
        .valid    (st_q.valid),
        .look_tag (look_tag),
        .match    (match),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    cache_lru i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (lru_victim)
    );

    always_comb begin
        ctl_d         = ctl_q;
        st_d          = st_q;
        cpu_ack       = 1'b0;
        dma_ack       = 1'b0;
        pf_ack        = 1'b0;
        flush_done    = 1'b0;
        ram_req       = 1'b0;
        ram_we        = 1'b0;
        ram_line_addr = ctl_q.miss_tag;
        ram_wline     = st_q.lines[ctl_q.slot];
        touch_en      = 1'b0;
        touch_idx     = hit_idx;
        start_miss    = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (sel_dma || sel_cpu) begin
                    if (hit) begin
                        dma_ack  = sel_dma;
                        cpu_ack  = sel_cpu;
                        touch_en = 1'b1;
                        if (req_we) begin
                            st_d.lines[hit_idx][int'(ofs)*WORD_W +: WORD_W] = req_wdata;
                            st_d.dirty[hit_idx] = 1'b1;
                        end
                    end else begin
                        start_miss = 1'b1;
                    end
                end else if (sel_flush) begin
                    ctl_d.phase = PH_FLUSH;
                    ctl_d.slot  = '0;
                end else if (sel_pf) begin
                    pf_ack = 1'b1;
                    if (!hit) start_miss = 1'b1;
                end
                if (start_miss) begin
                    ctl_d.slot         = victim;
                    ctl_d.miss_tag     = look_tag;
                    ctl_d.wb_for_flush = 1'b0;
                    ctl_d.phase = (st_q.valid[victim] && st_q.dirty[victim]) ? PH_EVICT : PH_FILL;
                end
            end
            PH_EVICT: begin
                ram_req       = 1'b1;
                ram_we        = 1'b1;
                ram_line_addr = st_q.tags[ctl_q.slot];
                if (ram_ack) begin
                    st_d.dirty[ctl_q.slot] = 1'b0;
                    ctl_d.phase = ctl_q.wb_for_flush ? PH_FLUSH : PH_FILL;
                end
            end
            PH_FILL: begin
                ram_req = 1'b1;
                if (ram_ack) begin
                    st_d.lines[ctl_q.slot] = ram_rline;
                    st_d.tags[ctl_q.slot]  = ctl_q.miss_tag;
                    st_d.valid[ctl_q.slot] = 1'b1;
                    st_d.dirty[ctl_q.slot] = 1'b0;
                    touch_en    = 1'b1;
                    touch_idx   = ctl_q.slot;
                    ctl_d.phase = PH_IDLE;
                end
            end
            PH_FLUSH: begin
                if (st_q.valid[ctl_q.slot] && st_q.dirty[ctl_q.slot]) begin
                    ctl_d.phase        = PH_EVICT;
                    ctl_d.wb_for_flush = 1'b1;
                end else if (ctl_q.slot == IDX_W'(NUM_LINES - 1)) begin
                    flush_done  = 1'b1;
                    ctl_d.phase = PH_IDLE;
                end else begin
                    ctl_d.slot = ctl_q.slot + 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            st_q  <= '0;
        end else begin
            ctl_q <= ctl_d;
            st_q  <= st_d;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R1
    AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req && !ram_ack |=> ram_req && $stable(ram_line_addr) && $stable(ram_we)); // R4
    AST_CLEAN_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_FILL) && ram_ack |=> !st_q.dirty[$past(ctl_q.slot)] && st_q.valid[$past(ctl_q.slot)]); // R3
    AST_PF_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req && !dma_req && !flush_req && (ctl_q.phase == PH_IDLE) |-> pf_ack); // R5
    AST_CPU_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> !cpu_ack && !dma_ack); // R6
    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_ack, dma_ack, pf_ack, flush_done})); // R10
endmodule

// File: tb/test_wb_line_cache.sv
`timescale 1ns/100ps
module test_wb_line_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        pf_req = 1'b0;
    logic [19:0] pf_addr = '0;
    logic        pf_ack;
    logic        dma_req = 1'b0, dma_we = 1'b0;
    logic [19:0] dma_addr = '0;
    logic [15:0] dma_wdata = '0;
    logic        dma_ack;
    logic [15:0] dma_rdata;
    logic        flush_req = 1'b0;
    logic        flush_done;
    logic        ram_req, ram_we;
    logic [13:0] ram_line_addr;
    logic [63:0] ram_wline;
    logic        ram_ack = 1'b0;
    logic [63:0] ram_rline = '0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, lat = 0;
    logic [15:0] ram_mem [int];
    logic [63:0] line_tmp;

    always #2 clk = ~clk;

    wb_line_cache #(.ADDR_IN_W(20)) i_wb_line_cache (.*);

    function automatic logic [15:0] ram_word(int a);
        if (ram_mem.exists(a)) return ram_mem[a];
        return ~a[15:0];
    endfunction

    // RAM model: three-cycle latency, one-cycle ack pulse
    always @(posedge clk) begin
        if (ram_ack) begin
            ram_ack <= 1'b0;
        end else if (ram_req) begin
            if (lat == 2) begin
                lat     <= 0;
                ram_ack <= 1'b1;
                if (ram_we) begin
                    for (int k = 0; k < 4; k++)
                        ram_mem[int'(ram_line_addr) * 4 + k] = ram_wline[k*16 +: 16];
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    for (int k = 0; k < 4; k++)
                        line_tmp[k*16 +: 16] = ram_word(int'(ram_line_addr) * 4 + k);
                    ram_rline <= line_tmp;
                    rd_cnt    <= rd_cnt + 1;
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cpu_op(input logic we, input logic [19:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output int waited);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        waited = 0;
        #1;
        while (!cpu_ack && waited < 1000) begin
            @(negedge clk); #1;
            waited++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic dma_op(input logic we, input logic [19:0] a, input logic [15:0] wd,
                          output logic [15:0] rd);
        int w;
        @(negedge clk);
        dma_req = 1'b1; dma_we = we; dma_addr = a; dma_wdata = wd;
        w = 0;
        #1;
        while (!dma_ack && w < 1000) begin
            @(negedge clk); #1;
            w++;
        end
        rd = dma_rdata;
        @(posedge clk); #1;
        dma_req = 1'b0;
    endtask

    task automatic pf_op(input logic [19:0] a, output logic acked_now);
        @(negedge clk);
        pf_req = 1'b1; pf_addr = a;
        #1;
        acked_now = pf_ack;
        while (!pf_ack) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        pf_req = 1'b0;
    endtask

    task automatic flush_op(output logic seen);
        int w;
        @(negedge clk);
        flush_req = 1'b1;
        w = 0;
        #1;
        while (!flush_done && w < 2000) begin
            @(negedge clk); #1;
            w++;
        end
        seen = flush_done;
        @(posedge clk); #1;
        flush_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [3:0]  rds;
        logic [3:0]  wrs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 20'h00010, 16'h0000, 16'hFFEF, 4'd1, 4'd0},  // R11 first access misses
        '{1'b1, 20'h00011, 16'h1234, 16'h0000, 4'd0, 4'd0},  // R3 store hit, no RAM write
        '{1'b0, 20'h00011, 16'h0000, 16'h1234, 4'd0, 4'd0},  // R3 stored value read back
        '{1'b0, 20'hF0010, 16'h0000, 16'hFFEF, 4'd0, 4'd0},  // R8 upper bits dropped
        '{1'b0, 20'h00013, 16'h0000, 16'hFFEC, 4'd0, 4'd0},  // R1 same line hits
        '{1'b0, 20'hA2000, 16'h0000, 16'hDFFF, 4'd1, 4'd0}   // R8 masked miss
    };

    initial begin
        logic [15:0] rd;
        logic        flag;
        int          w, r0, w0;

        do_reset();
        #1;
        chk(!cpu_ack && !dma_ack && !pf_ack && !flush_done && !ram_req, "R11 reset idle",
            {cpu_ack, dma_ack, pf_ack, flush_done, ram_req}, 0);

        // stimulus table
        foreach (VEC[i]) begin
            r0 = rd_cnt; w0 = wr_cnt;
            cpu_op(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd, w);
            if (!VEC[i].we) chk(rd == VEC[i].exp, "R8/R3 table data", rd, VEC[i].exp);
            chk(rd_cnt - r0 == int'(VEC[i].rds), "R11/R1 table ram reads", rd_cnt - r0, VEC[i].rds);
            chk(wr_cnt - w0 == int'(VEC[i].wrs), "R3 table ram writes", wr_cnt - w0, VEC[i].wrs);
        end

        // R1 / R2: capacity, empty-first, least recently used
        do_reset();
        r0 = rd_cnt;
        for (int t = 0; t < 16; t++) begin
            cpu_op(1'b0, 20'(t * 4), 16'h0, rd, w);
            chk(rd == ~16'(t * 4), "R4 fill word order", rd, ~16'(t * 4));
        end
        chk(rd_cnt - r0 == 16, "R1 sixteen fills", rd_cnt - r0, 16);
        r0 = rd_cnt;
        for (int t = 0; t < 16; t++) cpu_op(1'b0, 20'(t * 4 + 3), 16'h0, rd, w);
        chk(rd_cnt - r0 == 0, "R1/R2 all sixteen resident", rd_cnt - r0, 0);

        cpu_op(1'b1, 20'd12, 16'hC0DE, rd, w);
        cpu_op(1'b0, 20'd0, 16'h0, rd, w);
        r0 = rd_cnt; w0 = wr_cnt;
        cpu_op(1'b0, 20'd400, 16'h0, rd, w);
        chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R3 clean eviction no write", wr_cnt - w0, 0);
        r0 = rd_cnt;
        cpu_op(1'b0, 20'd4, 16'h0, rd, w);
        chk(rd_cnt - r0 == 1, "R2 oldest line replaced", rd_cnt - r0, 1);
        r0 = rd_cnt;
        cpu_op(1'b0, 20'd0, 16'h0, rd, w);
        chk(rd_cnt - r0 == 0, "R2 recent line kept", rd_cnt - r0, 0);
        for (int t = 4; t < 16; t++) cpu_op(1'b0, 20'(t * 4), 16'h0, rd, w);
        r0 = rd_cnt; w0 = wr_cnt;
        cpu_op(1'b0, 20'd800, 16'h0, rd, w);
        chk(wr_cnt - w0 == 1, "R3 dirty eviction writes", wr_cnt - w0, 1);
        chk(rd_cnt - r0 == 1, "R3 refill after writeback", rd_cnt - r0, 1);
        chk(ram_word(12) == 16'hC0DE, "R3 written word", ram_word(12), 16'hC0DE);
        chk(ram_word(13) == ~16'd13, "R4 whole line written", ram_word(13), ~16'd13);

        // R5: prefetch
        do_reset();
        for (int t = 0; t < 16; t++) cpu_op(1'b0, 20'(t * 4), 16'h0, rd, w);
        r0 = rd_cnt;
        pf_op(20'd0, flag);
        chk(flag, "R5 prefetch ack immediate", flag, 1);
        repeat (8) @(negedge clk);
        chk(rd_cnt - r0 == 0, "R5 resident prefetch no ram", rd_cnt - r0, 0);
        cpu_op(1'b0, 20'd200, 16'h0, rd, w);
        r0 = rd_cnt;
        cpu_op(1'b0, 20'd4, 16'h0, rd, w);
        chk(rd_cnt - r0 == 0, "R5 line 1 still resident", rd_cnt - r0, 0);
        cpu_op(1'b0, 20'd0, 16'h0, rd, w);
        chk(rd_cnt - r0 == 1, "R5 prefetch did not promote", rd_cnt - r0, 1);

        r0 = rd_cnt;
        pf_op(20'h03000, flag);
        chk(flag && rd_cnt == r0, "R5 ack before ram done", rd_cnt - r0, 0);
        cpu_op(1'b0, 20'h03001, 16'h0, rd, w);
        chk(rd == ~16'h3001, "R5 prefetched data", rd, ~16'h3001);
        chk(rd_cnt - r0 == 1, "R5 single fill for prefetch", rd_cnt - r0, 1);
        chk(w >= 2, "R6 cpu held during fill", w, 2);
        r0 = rd_cnt;
        cpu_op(1'b0, 20'h04000, 16'h0, rd, w);
        chk(w >= 3 && rd_cnt - r0 == 1, "R6 miss acked after line", w, 3);

        // R7: DMA through the cache
        r0 = rd_cnt; w0 = wr_cnt;
        dma_op(1'b1, 20'h00500, 16'hBEEF, rd);
        chk(rd_cnt - r0 == 1, "R7 dma miss fills", rd_cnt - r0, 1);
        cpu_op(1'b0, 20'h00500, 16'h0, rd, w);
        chk(rd == 16'hBEEF, "R7 cpu sees dma write", rd, 16'hBEEF);
        chk(wr_cnt == w0, "R7 no direct ram write", wr_cnt - w0, 0);
        cpu_op(1'b1, 20'h00501, 16'h7777, rd, w);
        dma_op(1'b0, 20'h80501, 16'h0, rd);
        chk(rd == 16'h7777, "R7 dma reads cached store", rd, 16'h7777);

        // R10: priority
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 20'h00500;
        dma_req = 1'b1; dma_we = 1'b0; dma_addr = 20'h00501;
        #1;
        chk(dma_ack && !cpu_ack, "R10 dma before cpu", {dma_ack, cpu_ack}, 2);
        chk(dma_rdata == 16'h7777, "R10 dma data", dma_rdata, 16'h7777);
        @(posedge clk); #1;
        dma_req = 1'b0;
        pf_req = 1'b1; pf_addr = 20'h00500;
        #0.1;
        chk(pf_ack && !cpu_ack, "R10 prefetch before cpu", {pf_ack, cpu_ack}, 2);
        @(posedge clk); #1;
        pf_req = 1'b0;
        #0.1;
        chk(cpu_ack && cpu_rdata == 16'hBEEF, "R10 cpu served last", cpu_rdata, 16'hBEEF);
        @(posedge clk); #1;
        cpu_req = 1'b0;

        // R9: flush
        w0 = wr_cnt;
        flush_op(flag);
        chk(flag, "R9 flush done seen", flag, 1);
        chk(wr_cnt - w0 == 1, "R9 one dirty line written", wr_cnt - w0, 1);
        chk(ram_word(16'h0500) == 16'hBEEF, "R9 ram word 0", ram_word(16'h0500), 16'hBEEF);
        chk(ram_word(16'h0501) == 16'h7777, "R9 ram word 1", ram_word(16'h0501), 16'h7777);
        w0 = wr_cnt;
        flush_op(flag);
        chk(flag && wr_cnt == w0, "R9 second flush writes nothing", wr_cnt - w0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule